// File: doc/BRIEF.md
# Boot-Trace Processor Variant Identifier

This block watches the bus of an 8-bit processor from the moment its reset line is released. It works out which of three compatible processor variants is fitted. No ready or sync line is available, so the block finds the start of the boot sequence by matching addresses. It then feeds the processor a minimal boot program: a reset vector pointing at `ENTRY`, and at that address an indirect jump whose pointer is `$FFFF`. The three variants form the target address of that jump in different ways, so each one produces a different run of bus addresses.

- An older part wraps the pointer's high-byte fetch inside the page. It reads `$FFFF` and then `$FF00`.
- A newer part spends one extra cycle re-reading the last operand byte. It then reads `$FFFF` and `$0000`.
- A third part reads `$FFFF` and then `$0000` with no extra cycle.

While detection is in progress, the block drives the data bus on every read. When the final address of a pattern has been seen, or a mismatch or a write has been seen, it latches a two-bit variant code. It also raises `done` and stops driving the bus. The result holds until the next reset.

Top module: `variant_sniffer`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `variant` is 00. After release, the block drives the bus (`data_oe`=1) on every read cycle (`rw`=1).
- R2: Before the first read of `$FFFC`, the block ignores all reads, including reads of `$FFFD`. Detection starts only at the first read of `$FFFC`. A read of `$FFFC` is served the low byte of `ENTRY` ($00). A read of `$FFFD` is served its high byte ($10).
- R3: The block serves opcode $6C at `ENTRY` ($1000) and $FF at `ENTRY`+1 and `ENTRY`+2. It serves $00 for every other address, including the pointer reads at `$FFFF`, `$FF00` and `$0000`.
- R4: The sequence `$FFFC,$FFFD,$1000,$1001,$1002,$FFFF,$FF00` gives `variant`=01 and `done`=1 one clock edge after the `$FF00` cycle.
- R5: The sequence `$FFFC,$FFFD,$1000,$1001,$1002,$1002,$FFFF,$0000` gives `variant`=10.
- R6: The sequence `$FFFC,$FFFD,$1000,$1001,$1002,$FFFF,$0000` gives `variant`=11.
- R7: After `$FFFC` has been seen, any address that does not fit one of the three patterns ends detection with `variant`=00 and `done`=1.
- R8: A write cycle (`rw`=0) during detection ends it with `variant`=00 and `done`=1.
- R9: Once `done` is 1, it stays 1 and `variant` stays unchanged until `rst_n` goes low. From then on, no bus activity changes them and `data_oe` stays 0.
- R10: `data_oe` is 0 on every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock; one edge per processor cycle |
| rst_n | input | 1 | Processor reset line, active low |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| data_out | output | 8 | Byte offered to the processor on reads |
| data_oe | output | 1 | Data bus drive enable |
| variant | output | 2 | 00 unknown, 01 wrap-bug part, 10 extra-cycle part, 11 exact part |
| done | output | 1 | Classification finished |

## Verification
The embedded assertions check the following on every cycle:
- `done` never falls without a reset.
- The code is frozen once `done` is set.
- A write during detection leads to an unknown result on the next edge.
- No code other than 00 appears before `done`.

Only the bench's scenarios can show the rest:
- That the right code comes out for each complete address pattern, including one preceded by stray reset-time reads.
- That each boot byte is served at its address.
- That a wrong pointer address is rejected.

// File: rtl/variant_sniffer.sv
module variant_sniffer #(
  parameter logic [15:0] ENTRY = 16'h1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rw,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic [1:0]  variant,
  output logic        done
);

  localparam logic [15:0] VEC_LO  = 16'hFFFC;
  localparam logic [15:0] VEC_HI  = 16'hFFFD;
  localparam logic [15:0] PTR     = 16'hFFFF;
  localparam logic [15:0] OPR1    = ENTRY + 16'd1;
  localparam logic [15:0] OPR2    = ENTRY + 16'd2;
  localparam logic [15:0] WRAPPED = {PTR[15:8], 8'h00};
  localparam logic [15:0] CARRIED = PTR + 16'd1;
  localparam logic [7:0]  JMP_IND = 8'h6C;

  localparam logic [1:0] V_NONE = 2'b00;
  localparam logic [1:0] V_WRAP = 2'b01;
  localparam logic [1:0] V_SLOW = 2'b10;
  localparam logic [1:0] V_FAST = 2'b11;

  typedef enum logic [3:0] {
    ST_WAIT, ST_VHI, ST_OPC, ST_OP1, ST_OP2,
    ST_PTR, ST_FORK, ST_BHI, ST_BLO, ST_FIN
  } st_t;

  st_t        st, st_nx;
  logic [1:0] code_nx;
  logic       fin_nx;

  always_comb begin
    data_out = 8'h00;
    case (addr)
      VEC_LO:     data_out = ENTRY[7:0];
      VEC_HI:     data_out = ENTRY[15:8];
      ENTRY:      data_out = JMP_IND;
      OPR1, OPR2: data_out = 8'hFF;
      default:    data_out = 8'h00;
    endcase
  end

  assign data_oe = rw && !done;

  always_comb begin
    st_nx   = st;
    code_nx = V_NONE;
    fin_nx  = 1'b0;
    if (!rw) begin
      fin_nx = 1'b1;
    end else begin
      case (st)
        ST_WAIT: if (addr == VEC_LO) st_nx = ST_VHI;
        ST_VHI:  if (addr == VEC_HI) st_nx = ST_OPC; else fin_nx = 1'b1;
        ST_OPC:  if (addr == ENTRY)  st_nx = ST_OP1; else fin_nx = 1'b1;
        ST_OP1:  if (addr == OPR1)   st_nx = ST_OP2; else fin_nx = 1'b1;
        ST_OP2:  if (addr == OPR2)   st_nx = ST_PTR; else fin_nx = 1'b1;
        ST_PTR: begin
          if (addr == PTR)       st_nx = ST_FORK;
          else if (addr == OPR2) st_nx = ST_BHI;
          else                   fin_nx = 1'b1;
        end
        ST_FORK: begin
          fin_nx = 1'b1;
          if (addr == WRAPPED)      code_nx = V_WRAP;
          else if (addr == CARRIED) code_nx = V_FAST;
        end
        ST_BHI:  if (addr == PTR) st_nx = ST_BLO; else fin_nx = 1'b1;
        ST_BLO: begin
          fin_nx = 1'b1;
          if (addr == CARRIED) code_nx = V_SLOW;
        end
        default: fin_nx = 1'b1;
      endcase
    end
    if (fin_nx) st_nx = ST_FIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT;
      variant <= V_NONE;
      done    <= 1'b0;
    end else if (!done) begin
      st <= st_nx;
      if (fin_nx) begin
        done    <= 1'b1;
        variant <= code_nx;
      end
    end
  end

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(variant));

  // R8
  write_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !rw) |=> (done && variant == V_NONE));

  // R1
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> variant == V_NONE);

endmodule

// File: tb/sim_variant_sniffer.sv
module sim_variant_sniffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rw = 1'b1;
  logic [7:0]  data_out;
  logic        data_oe;
  logic [1:0]  variant;
  logic        done;

  int errors = 0;
  int checks = 0;

  variant_sniffer u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw),
    .data_out(data_out), .data_oe(data_oe), .variant(variant), .done(done)
  );

  always #4 clk = ~clk;

  localparam int NSC = 6;
  localparam int MAXL = 10;
  localparam logic [16:0] SEQ [NSC][MAXL] = '{
    '{17'h1FFFC, 17'h1FFFD, 17'h11000, 17'h11001, 17'h11002, 17'h1FFFF, 17'h1FF00, 17'h0, 17'h0, 17'h0},
    '{17'h1FFFC, 17'h1FFFD, 17'h11000, 17'h11001, 17'h11002, 17'h11002, 17'h1FFFF, 17'h10000, 17'h0, 17'h0},
    '{17'h1FFFC, 17'h1FFFD, 17'h11000, 17'h11001, 17'h11002, 17'h1FFFF, 17'h10000, 17'h0, 17'h0, 17'h0},
    '{17'h101FF, 17'h1FFFD, 17'h10123, 17'h1FFFC, 17'h1FFFD, 17'h11000, 17'h11001, 17'h11002, 17'h1FFFF, 17'h10000},
    '{17'h1FFFC, 17'h1FFFD, 17'h11000, 17'h11001, 17'h11002, 17'h1FFFF, 17'h11234, 17'h0, 17'h0, 17'h0},
    '{17'h1FFFC, 17'h1FFFD, 17'h11000, 17'h00100, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0}
  };
  localparam int LEN [NSC] = '{7, 8, 7, 10, 7, 4};
  localparam logic [1:0] EXPV [NSC] = '{2'b01, 2'b10, 2'b11, 2'b11, 2'b00, 2'b00};
  localparam string TAG [NSC] = '{"R4", "R5", "R6", "R2", "R7", "R8"};

  function automatic logic [7:0] boot_byte(input logic [15:0] a);
    if (a == 16'hFFFD) return 8'h10;
    if (a == 16'h1000) return 8'h6C;
    if (a == 16'h1001 || a == 16'h1002) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    addr = 16'h0000;
    rw = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 done in reset", {15'd0, done}, 16'd0);
    chk("R1 variant in reset", {14'd0, variant}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic r, input logic [15:0] a, input string req);
    @(negedge clk);
    rw = r;
    addr = a;
    #2;
    chk("R10 drive enable", {15'd0, data_oe}, {15'd0, r});
    if (r) chk({req, " R3 served byte"}, {8'd0, data_out}, {8'd0, boot_byte(a)});
    chk({req, " not done yet"}, {15'd0, done}, 16'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSC; s++) begin
      do_reset();
      for (int i = 0; i < LEN[s]; i++) step(SEQ[s][i][16], SEQ[s][i][15:0], TAG[s]);
      @(posedge clk);
      #1;
      chk({TAG[s], " done"}, {15'd0, done}, 16'd1);
      chk({TAG[s], " variant"}, {14'd0, variant}, {14'd0, EXPV[s]});
    end

    do_reset();
    @(negedge clk);
    #2;
    chk("R1 drive after release", {15'd0, data_oe}, 16'd1);
    for (int i = 0; i < 7; i++) step(1'b1, SEQ[2][i][15:0], "R6");
    @(posedge clk);
    #1;
    chk("R6 variant", {14'd0, variant}, 16'd3);
    @(negedge clk);
    rw = 1'b0;
    addr = 16'h0200;
    #2;
    chk("R10 no drive on write", {15'd0, data_oe}, 16'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rw = i[0];
      addr = (i == 2) ? 16'hFFFC : 16'h1234;
      #2;
      chk("R9 no drive after done", {15'd0, data_oe}, 16'd0);
      @(posedge clk);
      #1;
      chk("R9 done held", {15'd0, done}, 16'd1);
      chk("R9 variant held", {14'd0, variant}, 16'd3);
    end
    do_reset();
    #1;
    chk("R9 reset clears done", {15'd0, done}, 16'd0);
    chk("R9 reset clears variant", {14'd0, variant}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule